// File: doc/BRIEF.md
# Seven-Level Stacked-Band PWM Modulator

This block produces the ten gate signals of a single-phase seven-level inverter. The inverter has a level stage of six fast switches, which can only build non-negative voltages (zero, one third, two thirds and all of the DC link). It also has a full bridge of four slow switches that sets the sign of the output. The block takes a signed sample of the reference sinusoid and a fractional modulation index. It scales the magnitude of the reference so that full modulation spans three carrier heights. It then compares that magnitude with a symmetric triangular carrier, inside whichever of three stacked bands the magnitude lies in.

The magnitude and sign are captured only at the carrier valley, so each carrier period works from one stable sample. The chosen level is decoded into one of four fixed level-stage patterns. The sign of the sample picks the forward or reverse bridge pair. A sequencer inserts a programmable all-off interval of DT clocks before any new level-stage pattern or bridge pair is applied. The bridge is allowed to swap only while the level stage holds the zero-level pattern. When the sign changes, the level stage is first driven to zero so that the swap can happen. A small index uses one band and gives three output levels; a middle index uses two bands and gives five; a large index uses all three and gives seven.

Top module: `pwm7_modulator`

## Requirements
- R1: While `rst` is high, and on the clock after it is applied, all six `gate_lvl` bits and all four `gate_pol` bits are 0.
- R2: The scaled magnitude is floor(|ref_in| * mod_idx * 3 * CARR_MAX / 2^(REF_W-1+MI_W)). The magnitude and the sign (negative when `ref_in` < 0, otherwise positive) are captured only on clock edges where the carrier is 0. A change of `ref_in` that starts and ends between two valleys has no effect on any gate.
- R3: The carrier counts 0, 1, ..., CARR_MAX, CARR_MAX-1, ..., 1, 0 and repeats, so one period is 2*CARR_MAX clocks. Each clock the selected level is registered as band + (mag - band*CARR_MAX > carrier), where band = min(floor(mag/CARR_MAX), 2).
- R4: The level-stage patterns, with bit i of `gate_lvl` driving switch i+1, are: level 0 = 6'b101010 (switches 2, 4, 6), level 1 = 6'b011010 (switches 2, 4, 5), level 2 = 6'b000110 (switches 2, 3), level 3 = 6'b000001 (switch 1).
- R5: With bit i of `gate_pol` driving bridge switch i+7, forward (positive sample) is 4'b0011 and reverse (negative sample) is 4'b1100.
- R6: Every change of the level-stage pattern passes through `gate_lvl` = 0 for exactly DT clocks.
- R7: `gate_pol` changes only while `gate_lvl` shows the level-0 pattern. Between the two pairs, `gate_pol` is 0 for exactly DT clocks.
- R8: While the captured sign differs from the applied bridge pair, the level-stage target is level 0. No level-stage pattern other than level 0 is shown while `gate_pol` is 0.
- R9: If the sinusoid peak gives a magnitude below CARR_MAX, only levels 0 and 1 appear. Below 2*CARR_MAX, levels 0 to 2 appear. At or above 2*CARR_MAX, all four levels appear.
- R10: `gate_lvl` is always 0 or one of the four patterns of R4. `gate_pol` is always 0, 4'b0011 or 4'b1100. No pattern changes directly into another non-zero pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | REF_W | Signed reference sample, two's complement |
| mod_idx | input | MI_W | Modulation index as the fraction mod_idx / 2^MI_W |
| gate_lvl | output | 6 | Level-stage gates, bit i drives switch i+1 |
| gate_pol | output | 4 | Bridge gates, bit i drives switch i+7 |

## Verification
The case hardest to reach from the ports is a sign reversal while the level stage is at its top level. In that case the block must first step the level stage down to zero through a dead time, then open the bridge for a dead time, and only then close the opposite pair. A smooth sinusoid reaches the zero crossing with the level already near zero, so it never creates this case. The stimulus therefore holds a large positive reference and then jumps it to a large negative value. Before the jump, a one-clock negative spike is placed mid-carrier, timed from the bench model's carrier position, to show that samples between valleys are ignored.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;

  localparam logic [3:0] POL_FWD = 4'b0011;
  localparam logic [3:0] POL_REV = 4'b1100;

  typedef enum logic [1:0] {
    SQ_RUN   = 2'd0,
    SQ_LDEAD = 2'd1,
    SQ_PDEAD = 2'd2
  } seq_state_e;

  function automatic logic [5:0] lvl_pattern(input logic [1:0] lvl);
    case (lvl)
      2'd0:    lvl_pattern = 6'b101010;
      2'd1:    lvl_pattern = 6'b011010;
      2'd2:    lvl_pattern = 6'b000110;
      default: lvl_pattern = 6'b000001;
    endcase
  endfunction

  function automatic logic [3:0] pol_pattern(input logic neg);
    pol_pattern = neg ? POL_REV : POL_FWD;
  endfunction

endpackage

// File: rtl/pwm7_carrier.sv
module pwm7_carrier #(
  parameter int CARR_MAX = 5000,
  localparam int CW = $clog2(CARR_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] carrier,
  output logic          valley
);

  logic up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier <= '0;
      up_q    <= 1'b1;
    end else if (up_q) begin
      carrier <= carrier + CW'(1);
      if (carrier == CW'(CARR_MAX - 1)) up_q <= 1'b0;
    end else begin
      carrier <= carrier - CW'(1);
      if (carrier == CW'(1)) up_q <= 1'b1;
    end
  end

  assign valley = (carrier == '0);

  // R3: carrier stays within its range
  p_carrier_range_r3: assert property (@(posedge clk) disable iff (rst)
    carrier <= CW'(CARR_MAX));

  // R3: carrier moves by exactly one every clock
  p_carrier_step_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (carrier == $past(carrier) + CW'(1)) || (carrier + CW'(1) == $past(carrier)));

endmodule

// File: rtl/pwm7_slicer.sv
module pwm7_slicer #(
  parameter int CARR_MAX = 5000,
  parameter int REF_W    = 16,
  parameter int MI_W     = 8,
  localparam int CW = $clog2(CARR_MAX + 1),
  localparam int MW = $clog2(3 * CARR_MAX + 1),
  localparam int PW = REF_W + MI_W + MW,
  localparam int SH = REF_W - 1 + MI_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [MI_W-1:0]         mod_idx,
  input  logic [CW-1:0]           carrier,
  input  logic                    valley,
  output logic [1:0]              level,
  output logic                    sign_neg
);

  logic [REF_W-1:0] abs_ref;
  logic [PW-1:0]    prod;
  logic [MW-1:0]    mag_c, mag_q, base, resid;
  logic [1:0]       band;
  logic             above;

  always_comb begin
    abs_ref = ref_in[REF_W-1] ? REF_W'(-ref_in) : REF_W'(ref_in);
    prod    = PW'(abs_ref) * PW'(mod_idx) * PW'(3 * CARR_MAX);
    mag_c   = MW'(prod >> SH);
  end

  // magnitude and sign are captured once per carrier period, at the valley
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q    <= '0;
      sign_neg <= 1'b0;
    end else if (valley) begin
      mag_q    <= mag_c;
      sign_neg <= ref_in[REF_W-1];
    end
  end

  always_comb begin
    if (mag_q >= MW'(2 * CARR_MAX)) begin
      band = 2'd2;
      base = MW'(2 * CARR_MAX);
    end else if (mag_q >= MW'(CARR_MAX)) begin
      band = 2'd1;
      base = MW'(CARR_MAX);
    end else begin
      band = 2'd0;
      base = '0;
    end
    resid = mag_q - base;
    above = resid > MW'(carrier);
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 2'd0;
    else     level <= band + {1'b0, above};
  end

  // R9: a magnitude in the first band never yields more than level 1
  p_band_low_r9: assert property (@(posedge clk) disable iff (rst)
    (mag_q < MW'(CARR_MAX)) |=> level <= 2'd1);

  // R9: a magnitude below the top band never yields level 3
  p_band_mid_r9: assert property (@(posedge clk) disable iff (rst)
    (mag_q < MW'(2 * CARR_MAX)) |=> level <= 2'd2);

  // R2: the captured magnitude only moves right after a valley
  p_sample_valley_r2: assert property (@(posedge clk) disable iff (rst)
    !rst && !valley |=> $stable(mag_q));

endmodule

// File: rtl/pwm7_gate_seq.sv
module pwm7_gate_seq
  import pwm7_pkg::*;
#(
  parameter int DT = 50,
  localparam int DTW = (DT > 1) ? $clog2(DT) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] level_t,
  input  logic       sign_t,
  output logic [5:0] gate_lvl,
  output logic [3:0] gate_pol
);

  seq_state_e     st_q, st_n;
  logic [DTW-1:0] cnt_q, cnt_n;
  logic [1:0]     lq_q, lq_n;
  logic           lon_q, lon_n, pq_q, pq_n, pon_q, pon_n;
  logic           pol_ok, at_zero, lvl_match, dt_done;
  logic [1:0]     tgt;

  always_comb begin
    pol_ok    = pon_q && (pq_q == sign_t);
    tgt       = pol_ok ? level_t : 2'd0;
    at_zero   = lon_q && (lq_q == 2'd0);
    lvl_match = lon_q && (lq_q == tgt);
    dt_done   = (cnt_q == DTW'(DT - 1));

    st_n  = st_q;
    cnt_n = cnt_q;
    lq_n  = lq_q;
    lon_n = lon_q;
    pq_n  = pq_q;
    pon_n = pon_q;

    case (st_q)
      SQ_RUN: begin
        if (!pol_ok && at_zero) begin
          st_n  = SQ_PDEAD;
          pon_n = 1'b0;
          cnt_n = '0;
        end else if (!lvl_match) begin
          st_n  = SQ_LDEAD;
          lon_n = 1'b0;
          cnt_n = '0;
        end
      end
      SQ_LDEAD: begin
        if (dt_done) begin
          lq_n  = tgt;
          lon_n = 1'b1;
          st_n  = SQ_RUN;
        end else begin
          cnt_n = cnt_q + DTW'(1);
        end
      end
      SQ_PDEAD: begin
        if (dt_done) begin
          pq_n  = sign_t;
          pon_n = 1'b1;
          st_n  = SQ_RUN;
        end else begin
          cnt_n = cnt_q + DTW'(1);
        end
      end
      default: st_n = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_RUN;
      cnt_q    <= '0;
      lq_q     <= 2'd0;
      lon_q    <= 1'b0;
      pq_q     <= 1'b0;
      pon_q    <= 1'b0;
      gate_lvl <= '0;
      gate_pol <= '0;
    end else begin
      st_q     <= st_n;
      cnt_q    <= cnt_n;
      lq_q     <= lq_n;
      lon_q    <= lon_n;
      pq_q     <= pq_n;
      pon_q    <= pon_n;
      gate_lvl <= lon_n ? lvl_pattern(lq_n) : 6'b000000;
      gate_pol <= pon_n ? pol_pattern(pq_n) : 4'b0000;
    end
  end

  // R1: reset clears every gate
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (gate_lvl == 6'b0) && (gate_pol == 4'b0));

  // R10: only the four table patterns or all-off on the level stage
  p_lvl_legal_r10: assert property (@(posedge clk) disable iff (rst)
    (gate_lvl == 6'b0) || (gate_lvl == lvl_pattern(2'd0)) || (gate_lvl == lvl_pattern(2'd1)) ||
    (gate_lvl == lvl_pattern(2'd2)) || (gate_lvl == lvl_pattern(2'd3)));

  // R5: only one legal bridge pair or none
  p_pol_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_pol == 4'b0) || (gate_pol == POL_FWD) || (gate_pol == POL_REV));

  // R6: a live level pattern either holds or drops to all-off
  p_lvl_break_r6: assert property (@(posedge clk) disable iff (rst)
    (gate_lvl != 6'b0) |=> (gate_lvl == $past(gate_lvl)) || (gate_lvl == 6'b0));

  // R7: a live bridge pair either holds or opens
  p_pol_break_r7: assert property (@(posedge clk) disable iff (rst)
    (gate_pol != 4'b0) |=> (gate_pol == $past(gate_pol)) || (gate_pol == 4'b0));

  // R7: bridge moves only while the level stage sits at level 0
  p_pol_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (gate_pol == $past(gate_pol)) || (gate_lvl == lvl_pattern(2'd0)));

  // R8: with the bridge open the level stage shows nothing but level 0
  p_open_bridge_r8: assert property (@(posedge clk) disable iff (rst)
    (gate_pol == 4'b0) |-> (gate_lvl == 6'b0) || (gate_lvl == lvl_pattern(2'd0)));

endmodule

// File: rtl/pwm7_modulator.sv
module pwm7_modulator #(
  parameter int CARR_MAX = 5000,
  parameter int REF_W    = 16,
  parameter int MI_W     = 8,
  parameter int DT       = 50,
  localparam int CW = $clog2(CARR_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic [MI_W-1:0]         mod_idx,
  output logic [5:0]              gate_lvl,
  output logic [3:0]              gate_pol
);

  logic [CW-1:0] carrier;
  logic          valley;
  logic [1:0]    level;
  logic          sign_neg;

  pwm7_carrier #(.CARR_MAX(CARR_MAX)) u_carrier (
    .clk     (clk),
    .rst     (rst),
    .carrier (carrier),
    .valley  (valley)
  );

  pwm7_slicer #(
    .CARR_MAX (CARR_MAX),
    .REF_W    (REF_W),
    .MI_W     (MI_W)
  ) u_slicer (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .mod_idx  (mod_idx),
    .carrier  (carrier),
    .valley   (valley),
    .level    (level),
    .sign_neg (sign_neg)
  );

  pwm7_gate_seq #(.DT(DT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .level_t  (level),
    .sign_t   (sign_neg),
    .gate_lvl (gate_lvl),
    .gate_pol (gate_pol)
  );

endmodule

// File: tb/sim_pwm7_modulator.sv
module sim_pwm7_modulator;

  localparam int CLK_PERIOD = 10;
  localparam int C          = 12;
  localparam int RW         = 16;
  localparam int MW         = 8;
  localparam int DT         = 3;
  localparam int LINE_CYC   = 200 * 2 * C;
  localparam int WD_CYC     = 60000;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [RW-1:0] ref_in = '0;
  logic [MW-1:0]        mod_idx = '0;
  logic [5:0]           gate_lvl;
  logic [3:0]           gate_pol;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm7_modulator #(.CARR_MAX(C), .REF_W(RW), .MI_W(MW), .DT(DT)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .mod_idx(mod_idx),
    .gate_lvl(gate_lvl), .gate_pol(gate_pol)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural reference state
  int car, up, mag, sgn, lvm, ph, cnt, lq, lon, pq, pon;
  int exp_lvl, exp_pol;
  // observed-run trackers
  int lvl_run, pol_run, lvl_nz, pol_nz;
  int prev_pol;

  function automatic int pat_of(int l);
    case (l)
      0: return 42;   // 6'b101010
      1: return 26;   // 6'b011010
      2: return 6;    // 6'b000110
      default: return 1;
    endcase
  endfunction

  function automatic int pair_of(int neg);
    return neg ? 12 : 3;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_step();
    int pol_ok, tgt, band, resid, nl, a;
    if (rst) begin
      car = 0; up = 1; mag = 0; sgn = 0; lvm = 0;
      ph = 0; cnt = 0; lq = 0; lon = 0; pq = 0; pon = 0;
    end else begin
      pol_ok = (pon != 0) && (pq == sgn);
      tgt = pol_ok ? lvm : 0;
      if (ph == 0) begin
        if (!pol_ok && lon != 0 && lq == 0) begin ph = 2; pon = 0; cnt = 0; end
        else if (!(lon != 0 && lq == tgt)) begin ph = 1; lon = 0; cnt = 0; end
      end else if (ph == 1) begin
        if (cnt == DT - 1) begin lq = tgt; lon = 1; ph = 0; end else cnt++;
      end else begin
        if (cnt == DT - 1) begin pq = sgn; pon = 1; ph = 0; end else cnt++;
      end
      band = mag / C;
      if (band > 2) band = 2;
      resid = mag - band * C;
      nl = band + ((resid > car) ? 1 : 0);
      if (car == 0) begin
        a = int'(ref_in);
        sgn = (a < 0) ? 1 : 0;
        if (a < 0) a = -a;
        mag = int'((longint'(a) * longint'(mod_idx) * longint'(3 * C)) >>> (RW - 1 + MW));
      end
      lvm = nl;
      if (up != 0) begin car++; if (car == C) up = 0; end
      else begin car--; if (car == 0) up = 1; end
    end
    exp_lvl = (lon != 0) ? pat_of(lq) : 0;
    exp_pol = (pon != 0) ? pair_of(pq) : 0;
  endtask

  task automatic compare();
    int gl, gp;
    gl = int'(gate_lvl);
    gp = int'(gate_pol);
    check(gl == exp_lvl, "R4 level gates vs model (R3 R6 R8)", gl, exp_lvl);
    check(gp == exp_pol, "R5 bridge gates vs model (R2 R7)", gp, exp_pol);
    check(gl == 0 || gl == 42 || gl == 26 || gl == 6 || gl == 1, "R10 level pattern legal", gl, 42);
    check(gp == 0 || gp == 3 || gp == 12, "R10 bridge pattern legal", gp, 3);
    if (!rst && gp != prev_pol)
      check(gl == 42, "R7 bridge moved away from level 0", gl, 42);
    prev_pol = gp;
    if (rst) begin
      lvl_nz = 0; lvl_run = 0; pol_nz = 0; pol_run = 0;
    end else begin
      if (gl == 0) begin
        if (lvl_nz != 0) lvl_run++;
      end else begin
        if (lvl_nz != 0 && lvl_run > 0) check(lvl_run == DT, "R6 level dead time", lvl_run, DT);
        lvl_nz = 1; lvl_run = 0;
      end
      if (gp == 0) begin
        if (pol_nz != 0) pol_run++;
      end else begin
        if (pol_nz != 0 && pol_run > 0) check(pol_run == DT, "R7 bridge dead time", pol_run, DT);
        pol_nz = 1; pol_run = 0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_sine(int mi, int expect_pats, string req);
    bit [3:0] seen;
    int k;
    seen = '0;
    mod_idx = MW'(mi);
    for (int i = 0; i < LINE_CYC + 4 * C; i++) begin
      k = i % LINE_CYC;
      ref_in = RW'($rtoi(32767.0 * $sin(6.283185307179586 * real'(k) / real'(LINE_CYC))));
      tick();
      if (gate_lvl == 6'b101010) seen[0] = 1'b1;
      if (gate_lvl == 6'b011010) seen[1] = 1'b1;
      if (gate_lvl == 6'b000110) seen[2] = 1'b1;
      if (gate_lvl == 6'b000001) seen[3] = 1'b1;
    end
    check($countones(seen) == expect_pats, req, $countones(seen), expect_pats);
  endtask

  initial begin
    int bad_r8;
    prev_pol = 0;
    repeat (4) tick();
    check(gate_lvl == 6'b0, "R1 level gates in reset", int'(gate_lvl), 0);
    check(gate_pol == 4'b0, "R1 bridge gates in reset", int'(gate_pol), 0);
    rst = 1'b0;

    run_sine(205, 4, "R9 distinct levels, index 0.8");
    run_sine(128, 3, "R9 distinct levels, index 0.5");
    run_sine(51,  2, "R9 distinct levels, index 0.2");

    // hold a large positive reference
    mod_idx = 8'd255;
    ref_in  = 16'sd30000;
    repeat (300) tick();
    check(gate_pol == 4'b0011, "R5 forward pair for positive reference", int'(gate_pol), 3);
    check(gate_lvl == 6'b000001 || gate_lvl == 6'b000110 || gate_lvl == 6'b0,
          "R3 top band active at high index", int'(gate_lvl), 1);

    // one-clock negative spike placed mid-carrier must be ignored
    while (!(car == 5 && up == 1)) tick();
    ref_in = -16'sd30000;
    tick();
    ref_in = 16'sd30000;
    for (int i = 0; i < 100; i++) begin
      tick();
      check(gate_pol == 4'b0011, "R2 mid-carrier spike ignored", int'(gate_pol), 3);
    end

    // sign reversal from the top level
    ref_in = -16'sd30000;
    bad_r8 = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (gate_pol != 4'b0011 && gate_pol != 4'b1100 &&
          gate_lvl != 6'b0 && gate_lvl != 6'b101010) bad_r8++;
    end
    check(bad_r8 == 0, "R8 level held at 0 during reversal", bad_r8, 0);
    check(gate_pol == 4'b1100, "R5 reverse pair for negative reference", int'(gate_pol), 12);

    // reset in mid-operation
    rst = 1'b1;
    tick();
    check(gate_lvl == 6'b0 && gate_pol == 4'b0, "R1 reset clears gates",
          int'({gate_pol, gate_lvl}), 0);
    rst = 1'b0;
    repeat (200) tick();
    check(gate_pol == 4'b1100, "R5 pair rebuilt after reset", int'(gate_pol), 12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: cycles=%0d expected<%0d", WD_CYC, WD_CYC);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule